// File: doc/BRIEF.md
# Multiplexed Bus Register and RAM Port

This block is the host-facing port of a real-time clock device. A host reaches 128 byte locations over one shared 8-bit address/data bus. Each access is a bus cycle made of two phases: an address phase, in which the location number is placed on the bus and captured when the address strobe drops, and a data phase, in which the data strobe and the read/write line move the byte in one direction or the other. A static mode pin selects one of two strobe conventions. In the first, the data strobe is a high-true enable and the read/write line gives the direction. In the second, the data strobe is an active-low read and the read/write line is an active-low write.

The 128 locations split into clock and control bytes and general-purpose RAM. The first fourteen locations and a century byte belong to the clock side. Two of these are status bytes that are supplied from outside and cannot be written. The other 113 locations are RAM. Bit 6 of the address chooses between the lower and the upper 64 locations. An active-low clear input fills every RAM byte with ones and leaves the clock side untouched. Each committed write to a writable clock byte is passed on as a one-cycle strobe, so the timekeeping logic can pick it up.

All bus inputs are sampled by the block clock through a synchronizer, so the strobes must be slow compared with that clock. The data bus is split into an input, an output and an output enable, which an external pad turns into the tri-state pin.

Top module: `mxbus_regram`

## Requirements
- R1: The address is taken from bits 6:0 of the bus when the address strobe falls while chip select is low. Bit 7 of the address byte is ignored, and the latched address stays unchanged until the next such falling edge.
- R2: With `bus_moto` = 1, `bus_ds` high with `bus_rw` = 1 is a read, and `bus_ds` high with `bus_rw` = 0 is a write. The written byte is the bus value last sampled before `bus_ds` falls.
- R3: With `bus_moto` = 0, `bus_ds` low is a read (active-low read) and `bus_rw` low is a write (active-low write). The byte is committed when `bus_rw` returns high.
- R4: `ad_oe` is high only during a read data phase. Whenever `ad_oe` is low, `ad_out` is 0, including during address phases and write data phases.
- R5: Locations 0x00 to 0x0B and the century byte at 0x32 are writable clock bytes. Every location from 0x0E to 0x7F except 0x32 is general RAM (113 bytes), and every writable location reads back the last value written to it.
- R6: Location 0x0C reads the `sts_lo_in` input and 0x0D reads `sts_hi_in`. Writes to either are ignored and produce no strobe.
- R7: Address bit 6 selects the upper 64 locations (0x40 to 0x7F), which have storage separate from 0x00 to 0x3F.
- R8: While `ram_clr_n` is low, all 113 RAM bytes become 0xFF. Clock bytes, including the century byte, keep their values.
- R9: When a write commits during a clear, the clear wins for a RAM byte, which reads 0xFF afterwards. A write to a clock byte in the same cycle still takes effect.
- R10: Each committed write to a writable clock byte raises `reg_wr_stb` for exactly one cycle, with the location on `reg_wr_addr` and the byte on `reg_wr_data`. Writes to RAM or to status bytes give no strobe.
- R11: After reset, `ad_oe` and `reg_wr_stb` are 0 and every stored location reads 0.
- R12: While chip select is high, no address is latched, no write commits and `ad_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all bus inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_moto | input | 1 | Strobe convention: 1 = enable plus direction, 0 = separate active-low read and write |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_as | input | 1 | Address strobe; the address is taken on its falling edge |
| bus_ds | input | 1 | Data strobe (high-true enable, or active-low read) |
| bus_rw | input | 1 | Direction (1 = read), or active-low write |
| ad_in | input | DW | Bus value as seen from the pad |
| ad_out | output | DW | Read data toward the pad, 0 when not driving |
| ad_oe | output | 1 | Pad output enable |
| ram_clr_n | input | 1 | Active-low clear of the general RAM |
| sts_lo_in | input | DW | Read-only status byte shown at 0x0C |
| sts_hi_in | input | DW | Read-only status byte shown at 0x0D |
| reg_wr_stb | output | 1 | One-cycle pulse for a committed clock-byte write |
| reg_wr_addr | output | AW | Location of that write |
| reg_wr_data | output | DW | Byte of that write |

## Verification
A RAM clear and a write commit can land in the same clock cycle. Both act on the same storage cells, and the order of priority decides what survives. The bench holds `ram_clr_n` low across complete write cycles, one to a RAM location and one to a clock byte, so each commit falls inside the clear window. It then releases the clear and reads both locations back. The RAM location must hold 0xFF, while the clock byte must show the written value and have produced its strobe.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

   // Location map of the 128-byte space
   localparam int CLK_RW_LAST = 11;   // last writable clock byte in the low block
   localparam int STS_LO      = 12;   // read-only status byte
   localparam int STS_HI      = 13;   // read-only status byte
   localparam int CLK_LAST    = 13;   // last clock/control location
   localparam int CENTURY     = 50;   // century byte

   // Control lines of the bus, sampled together with the data lines
   typedef struct packed {
      logic cs_n;
      logic as;
      logic ds;
      logic rw;
      logic clr_n;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, as: 1'b0, ds: 1'b0, rw: 1'b1, clr_n: 1'b1};

   function automatic logic is_gp(input int a);
      return (a > CLK_LAST) && (a != CENTURY);
   endfunction

   function automatic logic is_clk_rw(input int a);
      return (a <= CLK_RW_LAST) || (a == CENTURY);
   endfunction

   function automatic logic is_sts(input int a);
      return (a == STS_LO) || (a == STS_HI);
   endfunction

endpackage

// File: rtl/mxbus_sync.sv
module mxbus_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/mxbus_phase.sv
module mxbus_phase
   import mxbus_pkg::*;
#(
   parameter int AW = 7,
   parameter int DW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          moto,
   input  ctl_t          cur_ctl,
   input  logic [DW-1:0] cur_ad,
   output logic [AW-1:0] addr_q,
   output logic          addr_cap,
   output logic          rd_act,
   output logic          commit,
   output logic [DW-1:0] wr_data,
   output logic          clr_act,
   output logic          cs_act
);

   ctl_t          prev_ctl;
   logic [DW-1:0] prev_ad;
   logic          wr_cur;
   logic          wr_prev;

   function automatic logic wr_phase(input ctl_t c, input logic m);
      return !c.cs_n && !c.rw && (m ? c.ds : 1'b1);
   endfunction

   function automatic logic rd_phase(input ctl_t c, input logic m);
      return !c.cs_n && c.rw && (m ? c.ds : !c.ds);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ctl <= CTL_IDLE;
         prev_ad  <= '0;
         addr_q   <= '0;
      end else begin
         prev_ctl <= cur_ctl;
         prev_ad  <= cur_ad;
         if (addr_cap) begin
            addr_q <= prev_ad[AW-1:0];
         end
      end
   end

   // Address taken from the last sample with the strobe still high
   assign addr_cap = prev_ctl.as && !cur_ctl.as && !prev_ctl.cs_n;

   assign wr_cur  = wr_phase(cur_ctl, moto);
   assign wr_prev = wr_phase(prev_ctl, moto);

   // Trailing edge of a write phase commits the byte held just before it
   assign commit  = wr_prev && !wr_cur;
   assign wr_data = prev_ad;

   assign rd_act  = rd_phase(cur_ctl, moto) && !wr_cur;
   assign clr_act = !cur_ctl.clr_n;
   assign cs_act  = !cur_ctl.cs_n;

endmodule

// File: rtl/mxbus_store.sv
module mxbus_store
   import mxbus_pkg::*;
#(
   parameter int AW     = 7,
   parameter int DW     = 8,
   parameter int EXT_EN = 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          commit,
   input  logic [DW-1:0] wr_data,
   input  logic          clr_act,
   input  logic [DW-1:0] sts_lo,
   input  logic [DW-1:0] sts_hi,
   output logic [DW-1:0] rd_data,
   output logic          wr_stb,
   output logic [AW-1:0] wr_stb_addr,
   output logic [DW-1:0] wr_stb_data
);

   localparam int DEPTH = 1 << AW;
   localparam int HALF  = DEPTH / 2;

   logic [DEPTH*DW-1:0] img;

   for (genvar i = 0; i < DEPTH; i++) begin : g_loc
      if (i == STS_LO) begin : g_sts_lo
         assign img[i*DW +: DW] = sts_lo;
      end else if (i == STS_HI) begin : g_sts_hi
         assign img[i*DW +: DW] = sts_hi;
      end else if ((i >= HALF) && (EXT_EN == 0)) begin : g_absent
         assign img[i*DW +: DW] = '1;
      end else begin : g_cell
         logic [DW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (clr_act && is_gp(i)) begin
               q <= '1;
            end else if (commit && (addr == AW'(i))) begin
               q <= wr_data;
            end
         end
         assign img[i*DW +: DW] = q;
      end
   end

   assign rd_data = img[int'(addr)*DW +: DW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb      <= 1'b0;
         wr_stb_addr <= '0;
         wr_stb_data <= '0;
      end else begin
         wr_stb <= commit && is_clk_rw(int'(addr));
         if (commit) begin
            wr_stb_addr <= addr;
            wr_stb_data <= wr_data;
         end
      end
   end

endmodule

// File: rtl/mxbus_regram.sv
module mxbus_regram
   import mxbus_pkg::*;
#(
   parameter int AW          = 7,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int EXT_EN      = 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_moto,
   input  logic          bus_cs_n,
   input  logic          bus_as,
   input  logic          bus_ds,
   input  logic          bus_rw,
   input  logic [DW-1:0] ad_in,
   output logic [DW-1:0] ad_out,
   output logic          ad_oe,
   input  logic          ram_clr_n,
   input  logic [DW-1:0] sts_lo_in,
   input  logic [DW-1:0] sts_hi_in,
   output logic          reg_wr_stb,
   output logic [AW-1:0] reg_wr_addr,
   output logic [DW-1:0] reg_wr_data
);

   localparam int CW = $bits(ctl_t);
   localparam int SW = CW + DW;

   if (AW < 6) begin : g_bad_aw
      $error("mxbus_regram: AW must reach the century location");
   end
   if (DW < AW) begin : g_bad_dw
      $error("mxbus_regram: the address must fit on the data bus");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("mxbus_regram: at least one sampling stage is needed");
   end

   ctl_t          raw_ctl;
   ctl_t          cur_ctl;
   logic [DW-1:0] cur_ad;
   logic [SW-1:0] smp;

   logic [AW-1:0] addr_q;
   logic          addr_cap;
   logic          rd_act;
   logic          commit;
   logic [DW-1:0] wr_data;
   logic          clr_act;
   logic          cs_act;
   logic [DW-1:0] rd_data;

   assign raw_ctl = '{cs_n: bus_cs_n, as: bus_as, ds: bus_ds, rw: bus_rw, clr_n: ram_clr_n};

   mxbus_sync #(
      .W       (SW),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({CTL_IDLE, {DW{1'b0}}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({raw_ctl, ad_in}),
      .q     (smp)
   );

   assign cur_ctl = smp[SW-1:DW];
   assign cur_ad  = smp[DW-1:0];

   mxbus_phase #(
      .AW (AW),
      .DW (DW)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .moto     (bus_moto),
      .cur_ctl  (cur_ctl),
      .cur_ad   (cur_ad),
      .addr_q   (addr_q),
      .addr_cap (addr_cap),
      .rd_act   (rd_act),
      .commit   (commit),
      .wr_data  (wr_data),
      .clr_act  (clr_act),
      .cs_act   (cs_act)
   );

   mxbus_store #(
      .AW     (AW),
      .DW     (DW),
      .EXT_EN (EXT_EN)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (addr_q),
      .commit      (commit),
      .wr_data     (wr_data),
      .clr_act     (clr_act),
      .sts_lo      (sts_lo_in),
      .sts_hi      (sts_hi_in),
      .rd_data     (rd_data),
      .wr_stb      (reg_wr_stb),
      .wr_stb_addr (reg_wr_addr),
      .wr_stb_data (reg_wr_data)
   );

   assign ad_oe  = rd_act;
   assign ad_out = rd_act ? rd_data : '0;

endmodule

// File: rtl/mxbus_regram_chk.sv
module mxbus_regram_chk #(
   parameter int AW = 7,
   parameter int DW = 8
)(
   input logic          clk,
   input logic          rst_n,
   input logic          ad_oe,
   input logic [DW-1:0] ad_out,
   input logic          reg_wr_stb,
   input logic [AW-1:0] reg_wr_addr,
   input logic          addr_cap,
   input logic [AW-1:0] addr_q,
   input logic          cs_act
);

   // R4: an undriven bus carries zeros
   assert_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ad_oe |-> (ad_out == '0));

   // R12: no drive without a selected device
   assert_cs_gates_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !ad_oe);

   // R10: the write strobe lasts one cycle
   assert_stb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_stb |=> !reg_wr_stb);

   // R10: the strobe only names writable clock bytes
   assert_stb_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_stb |-> ((reg_wr_addr <= AW'(11)) || (reg_wr_addr == AW'(50))));

   // R1: the latched address moves only on a capture
   assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_cap |=> $stable(addr_q));

endmodule

bind mxbus_regram mxbus_regram_chk #(
   .AW (AW),
   .DW (DW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ad_oe       (ad_oe),
   .ad_out      (ad_out),
   .reg_wr_stb  (reg_wr_stb),
   .reg_wr_addr (reg_wr_addr),
   .addr_cap    (addr_cap),
   .addr_q      (addr_q),
   .cs_act      (cs_act)
);

// File: tb/mxbus_regram_tb.sv
module mxbus_regram_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_moto = 1'b1;
   logic       bus_cs_n = 1'b1;
   logic       bus_as = 1'b0;
   logic       bus_ds = 1'b0;
   logic       bus_rw = 1'b1;
   logic [7:0] ad_in = 8'h00;
   logic [7:0] ad_out;
   logic       ad_oe;
   logic       ram_clr_n = 1'b1;
   logic [7:0] sts_lo_in = 8'hA5;
   logic [7:0] sts_hi_in = 8'h80;
   logic       reg_wr_stb;
   logic [6:0] reg_wr_addr;
   logic [7:0] reg_wr_data;

   int ntests = 0;
   int nfail  = 0;
   bit done   = 1'b0;

   logic [7:0] model [128];
   bit         clr_on = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   int         stb_cnt = 0;
   logic [6:0] stb_addr = '0;
   logic [7:0] stb_data = '0;

   always #5 clk = ~clk;

   mxbus_regram u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_moto    (bus_moto),
      .bus_cs_n    (bus_cs_n),
      .bus_as      (bus_as),
      .bus_ds      (bus_ds),
      .bus_rw      (bus_rw),
      .ad_in       (ad_in),
      .ad_out      (ad_out),
      .ad_oe       (ad_oe),
      .ram_clr_n   (ram_clr_n),
      .sts_lo_in   (sts_lo_in),
      .sts_hi_in   (sts_hi_in),
      .reg_wr_stb  (reg_wr_stb),
      .reg_wr_addr (reg_wr_addr),
      .reg_wr_data (reg_wr_data)
   );

   function automatic bit tb_is_ram(input int a);
      return (a >= 14) && (a != 50);
   endfunction

   function automatic logic [7:0] expect_at(input int a);
      if (a == 12) return sts_lo_in;
      if (a == 13) return sts_hi_in;
      return model[a];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      ntests++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Monitor: holds the last driven byte and pops an expectation when the drive ends
   logic       oe_d = 1'b0;
   logic [7:0] last_rd = '0;
   always @(negedge clk) begin
      if (ad_oe) last_rd = ad_out;
      if (oe_d && !ad_oe) begin
         ntests++;
         if (exp_q.size() == 0) begin
            nfail++;
            $display("FAIL R4: actual 0x%0h expected no read", last_rd);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (last_rd !== e) begin
               nfail++;
               $display("FAIL %s: actual 0x%0h expected 0x%0h", t, last_rd, e);
            end
         end
      end
      oe_d = ad_oe;
      if (reg_wr_stb) begin
         stb_cnt++;
         stb_addr = reg_wr_addr;
         stb_data = reg_wr_data;
      end
   end

   task automatic idle_lines();
      bus_cs_n = 1'b1;
      bus_as   = 1'b0;
      bus_rw   = 1'b1;
      bus_ds   = bus_moto ? 1'b0 : 1'b1;
      ad_in    = 8'h00;
   endtask

   task automatic addr_phase(input logic [7:0] a, input bit sel);
      @(negedge clk);
      bus_cs_n = !sel;
      ad_in    = a;
      bus_as   = 1'b1;
      repeat (3) @(negedge clk);
      bus_as = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_end();
      @(negedge clk);
      idle_lines();
      repeat (4) @(negedge clk);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string tag);
      int idx;
      idx = int'(a[6:0]);
      addr_phase(a, 1'b1);
      ad_in  = d;
      bus_rw = 1'b0;
      if (bus_moto) bus_ds = 1'b1;
      repeat (3) @(negedge clk);
      chk(!ad_oe && ad_out == 8'h00, {tag, " R4 no drive in write"}, ad_oe, 0);
      repeat (2) @(negedge clk);
      if (bus_moto) bus_ds = 1'b0;
      else          bus_rw = 1'b1;
      repeat (3) @(negedge clk);
      bus_end();
      if (!(idx == 12 || idx == 13) && !(clr_on && tb_is_ram(idx))) model[idx] = d;
   endtask

   task automatic do_read(input logic [7:0] a, input string tag);
      exp_q.push_back(expect_at(int'(a[6:0])));
      tag_q.push_back(tag);
      addr_phase(a, 1'b1);
      chk(!ad_oe, {tag, " R4 no drive in address phase"}, ad_oe, 0);
      bus_rw = 1'b1;
      bus_ds = bus_moto ? 1'b1 : 1'b0;
      repeat (6) @(negedge clk);
      bus_ds = bus_moto ? 1'b0 : 1'b1;
      repeat (3) @(negedge clk);
      bus_end();
   endtask

   task automatic set_mode(input bit m);
      @(negedge clk);
      bus_moto = m;
      idle_lines();
      repeat (4) @(negedge clk);
   endtask

   task automatic clear_pulse();
      @(negedge clk);
      ram_clr_n = 1'b0;
      clr_on    = 1'b1;
      for (int i = 0; i < 128; i++) if (tb_is_ram(i)) model[i] = 8'hFF;
      repeat (5) @(negedge clk);
      ram_clr_n = 1'b1;
      clr_on    = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         ntests++;
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

   initial begin
      int s0;
      for (int i = 0; i < 128; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R11: reset state
      chk(ad_oe == 1'b0, "R11 oe after reset", ad_oe, 0);
      chk(reg_wr_stb == 1'b0, "R11 strobe after reset", reg_wr_stb, 0);
      do_read(8'h00, "R11 clock byte zero");
      do_read(8'h47, "R11 upper RAM zero");

      // R2, R5: enable-plus-direction convention
      do_write(8'h03, 8'h59, "R2");
      do_write(8'h32, 8'h20, "R5");
      do_write(8'h20, 8'hC3, "R5");
      do_write(8'h7F, 8'h11, "R5");
      do_read(8'h03, "R2 clock byte");
      do_read(8'h32, "R5 century");
      do_read(8'h20, "R5 lower RAM");
      do_read(8'h7F, "R5 top RAM");

      // R7: bit 6 picks separate storage; R1: bit 7 ignored
      do_write(8'h10, 8'h01, "R7");
      do_write(8'h50, 8'h02, "R7");
      do_read(8'h10, "R7 lower half");
      do_read(8'h50, "R7 upper half");
      do_write(8'h91, 8'h6B, "R1");
      do_read(8'h11, "R1 bit 7 ignored");

      // R10: strobe for clock bytes only
      s0 = stb_cnt;
      do_write(8'h05, 8'h37, "R10");
      chk(stb_cnt == s0 + 1, "R10 one strobe", stb_cnt - s0, 1);
      chk(stb_addr == 7'h05 && stb_data == 8'h37, "R10 strobe contents",
          {stb_addr, stb_data}, {7'h05, 8'h37});
      s0 = stb_cnt;
      do_write(8'h22, 8'h44, "R10");
      chk(stb_cnt == s0, "R10 no strobe for RAM", stb_cnt - s0, 0);

      // R6: status bytes read-only
      s0 = stb_cnt;
      do_write(8'h0C, 8'h00, "R6");
      do_write(8'h0D, 8'h7E, "R6");
      chk(stb_cnt == s0, "R6 no strobe for status", stb_cnt - s0, 0);
      do_read(8'h0C, "R6 status low");
      do_read(8'h0D, "R6 status high");
      @(negedge clk);
      sts_lo_in = 8'h3C;
      do_read(8'h0C, "R6 status follows input");

      // R3: separate active-low strobes
      set_mode(1'b0);
      do_write(8'h08, 8'h9A, "R3");
      do_write(8'h60, 8'hE1, "R3");
      do_read(8'h08, "R3 clock byte");
      do_read(8'h60, "R3 upper RAM");
      do_read(8'h20, "R3 earlier value");

      // R12: unselected cycles have no effect
      addr_phase(8'h21, 1'b0);
      ad_in  = 8'h77;
      bus_rw = 1'b0;
      repeat (4) @(negedge clk);
      bus_rw = 1'b1;
      bus_ds = 1'b0;
      repeat (4) @(negedge clk);
      chk(!ad_oe, "R12 no drive when unselected", ad_oe, 0);
      bus_end();
      do_read(8'h21, "R12 no write when unselected");

      // R8: clear fills RAM, keeps clock bytes
      clear_pulse();
      do_read(8'h0E, "R8 first RAM byte");
      do_read(8'h31, "R8 below century");
      do_read(8'h33, "R8 above century");
      do_read(8'h60, "R8 upper RAM");
      do_read(8'h32, "R8 century kept");
      do_read(8'h08, "R8 clock byte kept");

      // R9: writes that commit inside the clear window
      set_mode(1'b1);
      @(negedge clk);
      ram_clr_n = 1'b0;
      clr_on    = 1'b1;
      for (int i = 0; i < 128; i++) if (tb_is_ram(i)) model[i] = 8'hFF;
      s0 = stb_cnt;
      do_write(8'h24, 8'h5A, "R9");
      do_write(8'h07, 8'h3C, "R9");
      ram_clr_n = 1'b1;
      clr_on    = 1'b0;
      repeat (4) @(negedge clk);
      chk(stb_cnt == s0 + 1, "R9 clock strobe during clear", stb_cnt - s0, 1);
      do_read(8'h24, "R9 RAM cleared");
      do_read(8'h07, "R9 clock write kept");

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R4 every read driven", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

endmodule